// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregator

This block receives message-signaled interrupts as single-byte writes and turns them into level interrupt lines. Each message byte carries two fields: the two lowest bits choose one of four status registers, and the field above them chooses a bit inside that register. The chosen bit is set and stays set until software clears it. Every status register drives its own interrupt line, which stays high while any bit of that register is pending. Moving a source to another interrupt line keeps its bit index and changes only the two register-select bits of its message.

Software reaches the status registers through a simple register port. A read returns data one cycle later. A write acts as write-one-to-clear on the addressed status register. A build-time switch picks between the full variant, with 32 bits per register, and the reduced variant, where the bit field is three bits wide and only 8 bits per register exist. In the reduced variant a message whose bit field is out of range sets nothing and instead raises a sticky error flag.

Top module: `msg_irq_aggregator`

## Requirements
- R1: A message with msg_valid_i high sets bit msg_byte_i[6:2] of status register msg_byte_i[1:0] (full variant) at the next clock edge.
- R2: Bit 7 of the message byte has no effect: bytes that differ only in bit 7 set the same bit.
- R3: irq_o[k] is high exactly when status register k has any bit set. It changes in the same cycle as the register contents.
- R4: A register write (reg_valid_i and reg_write_i high) to address k, for k in 0..3, clears the bits of status register k that are 1 in reg_wdata_i and leaves the other bits unchanged.
- R5: When a message sets a bit and a write clears the same bit in the same cycle, the bit ends up set.
- R6: In the reduced variant (FULL_VARIANT=0) the bit field is msg_byte_i[4:2], and status bits 31:8 always read as 0.
- R7: In the reduced variant, a message with msg_byte_i[6:5] not zero sets no status bit and sets the sticky error flag. The flag is seen on err_o and as bit 0 at address 4. It clears only on a write to address 4 with wdata bit 0 set, and a new error in that same cycle wins over the clear.
- R8: A read (reg_valid_i high, reg_write_i low) returns on reg_rdata_o after the next edge the value that the addressed location held before that edge. Addresses 5 to 7 read as 0. reg_rdata_o holds its value while no read is issued.
- R9: After reset every status register, irq_o, err_o and reg_rdata_o are 0.
- R10: Messages to different registers with the same bit index build up independently in each register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | Message byte write strobe |
| msg_byte_i | input | 8 | Message byte |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write-one-to-clear, 0 = read |
| reg_addr_i | input | ADDR_W | 0..3 status registers, 4 error flag |
| reg_wdata_i | input | DATA_W | Clear mask |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the request |
| irq_o | output | 4 | Level interrupt, one per status register |
| err_o | output | 1 | Sticky out-of-range message flag |

## Verification
The assertions assume that msg_valid_i stays low while reset is active, so that every status bit that rises can be traced back to a message that was accepted. They also assume that inputs are stable around the clock edge. The bench changes all inputs only on the falling edge and keeps both strobes low until reset is released. It drives the same stimulus into a full-variant and a reduced-variant instance. This puts message/clear collisions, out-of-range bytes and bit-7 aliases in front of both variants.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int MSG_W    = 8;
  localparam int SEL_W    = 2;                // register-select field, bits 1:0
  localparam int NBANK    = 1 << SEL_W;
  localparam int IDX_MAXW = MSG_W - 1 - SEL_W; // bits 6:2, bit 7 unused
  localparam int IDX_REDW = 3;                 // reduced variant, bits 4:2

  function automatic int idx_width(input bit full);
    return full ? IDX_MAXW : IDX_REDW;
  endfunction
endpackage

// File: rtl/msg_decoder.sv
module msg_decoder
  import msi_agg_pkg::*;
#(
  parameter bit FULL_VARIANT = 1'b1,
  parameter int DATA_W       = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [MSG_W-1:0]              byte_i,
  output logic [NBANK-1:0][DATA_W-1:0]  set_vec_o,
  output logic                          err_pulse_o
);
  localparam int IDX_W = idx_width(FULL_VARIANT);

  logic [SEL_W-1:0] bank;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             unused_b7;

  assign bank      = byte_i[SEL_W-1:0];
  assign idx       = byte_i[SEL_W +: IDX_W];
  assign unused_b7 = byte_i[MSG_W-1];

  generate
    if (IDX_W < IDX_MAXW) begin : g_reduced
      assign in_range = (byte_i[SEL_W+IDX_W +: (IDX_MAXW-IDX_W)] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    set_vec_o = '0;
    if (valid_i && in_range) set_vec_o[bank][idx] = 1'b1;
  end

  assign err_pulse_o = valid_i && !in_range;

  assert_one_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_vec_o));
  assert_bad_no_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> (set_vec_o == '0));
  assert_idle_no_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (set_vec_o == '0 && !err_pulse_o));
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int DATA_W = 32,
  parameter int USED_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] USED_MASK =
    (USED_W >= DATA_W) ? '1 : ((DATA_W'(1) << USED_W) - DATA_W'(1));

  logic [DATA_W-1:0] q;

  // set after clear: a message never loses to a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & USED_MASK;
  end

  assign q_o   = q;
  assign irq_o = |q;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i) & ~$past(set_i)) == '0));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
  import msi_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NBANK-1:0][DATA_W-1:0] banks_i,
  input  logic                         err_i,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int ERR_ADDR = NBANK;

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    if (int'(addr_i) < NBANK)        sel = banks_i[addr_i[SEL_W-1:0]];
    else if (int'(addr_i) == ERR_ADDR) sel = DATA_W'(err_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/msg_irq_aggregator.sv
module msg_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter bit FULL_VARIANT = 1'b1,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [MSG_W-1:0]  msg_byte_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NBANK-1:0]  irq_o,
  output logic              err_o
);
  localparam int IDX_W    = idx_width(FULL_VARIANT);
  localparam int USED_W   = 1 << IDX_W;
  localparam int ERR_ADDR = NBANK;

  logic [NBANK-1:0][DATA_W-1:0] set_vec;
  logic [NBANK-1:0][DATA_W-1:0] bank_q;
  logic                         err_pulse;
  logic                         wr_en;
  logic                         rd_en;
  logic                         err_clr;
  logic                         err_q;

  assign wr_en   = reg_valid_i && reg_write_i;
  assign rd_en   = reg_valid_i && !reg_write_i;
  assign err_clr = wr_en && (int'(reg_addr_i) == ERR_ADDR) && reg_wdata_i[0];

  msg_decoder #(
    .FULL_VARIANT(FULL_VARIANT),
    .DATA_W      (DATA_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (msg_valid_i),
    .byte_i     (msg_byte_i),
    .set_vec_o  (set_vec),
    .err_pulse_o(err_pulse)
  );

  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
      logic [DATA_W-1:0] clr;
      assign clr = (wr_en && int'(reg_addr_i) == k) ? reg_wdata_i : '0;

      status_bank #(
        .DATA_W(DATA_W),
        .USED_W(USED_W)
      ) u_bank (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_vec[k]),
        .clr_i (clr),
        .q_o   (bank_q[k]),
        .irq_o (irq_o[k])
      );

      assert_irq_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o[k]) |-> $past(msg_valid_i));
      assert_irq_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o[k]) |-> $past(wr_en && int'(reg_addr_i) == k));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (err_q && !err_clr) || err_pulse;
  end

  assign err_o = err_q;

  reg_read_mux #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en),
    .addr_i (reg_addr_i),
    .banks_i(bank_q),
    .err_i  (err_q),
    .rdata_o(reg_rdata_o)
  );

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr) |=> err_o);
  assert_err_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(msg_valid_i));
endmodule

// File: tb/tb_msg_irq_aggregator.sv
module tb_msg_irq_aggregator;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic [7:0]    msg_byte = '0;
  logic          reg_valid = 1'b0;
  logic          reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;

  logic [DW-1:0] rd_f, rd_r;
  logic [3:0]    irq_f, irq_r;
  logic          err_f, err_r;

  always #2.5 clk = ~clk;

  msg_irq_aggregator #(.FULL_VARIANT(1'b1), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_byte_i(msg_byte),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_f), .irq_o(irq_f), .err_o(err_f));

  msg_irq_aggregator #(.FULL_VARIANT(1'b0), .DATA_W(DW), .ADDR_W(AW)) dut_red (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_byte_i(msg_byte),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_r), .irq_o(irq_r), .err_o(err_r));

  // behavioural reference: [0] full, [1] reduced
  logic [DW-1:0] m_stat [2][4];
  logic          m_err  [2];
  logic [DW-1:0] m_rd   [2];

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string cur_tag = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        for (int k = 0; k < 4; k++) m_stat[v][k] = '0;
        m_err[v] = 1'b0;
        m_rd[v]  = '0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        if (reg_valid && !reg_write) begin
          if (reg_addr < 4)       m_rd[v] = m_stat[v][reg_addr];
          else if (reg_addr == 4) m_rd[v] = {31'b0, m_err[v]};
          else                    m_rd[v] = '0;
        end
        if (reg_valid && reg_write) begin
          if (reg_addr < 4) m_stat[v][reg_addr] = m_stat[v][reg_addr] & ~reg_wdata;
          else if (reg_addr == 4 && reg_wdata[0]) m_err[v] = 1'b0;
        end
        if (msg_valid) begin
          if (v == 0) m_stat[0][msg_byte[1:0]][msg_byte[6:2]] = 1'b1;
          else if (msg_byte[6:5] == 2'b00) m_stat[1][msg_byte[1:0]][msg_byte[4:2]] = 1'b1;
          else m_err[1] = 1'b1;
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] ei [2];
    for (int v = 0; v < 2; v++)
      for (int k = 0; k < 4; k++) ei[v][k] = (m_stat[v][k] != '0);
    check("R3", "irq_full", DW'(irq_f), DW'(ei[0]));
    check("R3", "irq_red",  DW'(irq_r), DW'(ei[1]));
    check("R7", "err_full", DW'(err_f), DW'(m_err[0]));
    check("R7", "err_red",  DW'(err_r), DW'(m_err[1]));
    check(cur_tag, "rdata_full", rd_f, m_rd[0]);
    check(cur_tag, "rdata_red",  rd_r, m_rd[1]);
  end

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      report();
    end
  end

  task automatic idle();
    msg_valid = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic msg(input logic [7:0] b);
    msg_valid = 1'b1; msg_byte = b; reg_valid = 1'b0;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic rd(input int a);
    msg_valid = 1'b0; reg_valid = 1'b1; reg_write = 1'b0; reg_addr = AW'(a);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic clr(input int a, input logic [DW-1:0] m);
    msg_valid = 1'b0; reg_valid = 1'b1; reg_write = 1'b1; reg_addr = AW'(a); reg_wdata = m;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic msg_clr(input logic [7:0] b, input int a, input logic [DW-1:0] m);
    msg_valid = 1'b1; msg_byte = b;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = AW'(a); reg_wdata = m;
    @(negedge clk);
    msg_valid = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) begin
      rd(a);
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R9";   read_all();
    cur_tag = "R1";   msg(8'h00); msg(8'h7F); msg(8'h29); read_all();
    cur_tag = "R2";   msg(8'h86); rd(2); msg(8'h06); rd(2); msg(8'hFF); read_all();
    cur_tag = "R4";   clr(3, 32'h8000_0000); clr(1, 32'h0000_0001); read_all();
                      clr(0, '1); clr(1, '1); clr(2, '1); clr(3, '1); read_all();
    cur_tag = "R5";   msg(8'h05); msg_clr(8'h05, 1, '1); rd(1); msg_clr(8'h09, 1, 32'h6); read_all();
    cur_tag = "R6";   msg(8'h1F); msg(8'h1C); rd(3); rd(0); clr(3, 32'hFFFF_FF00); read_all();
    cur_tag = "R7";   msg(8'h20); rd(4); msg(8'h61); rd(4); clr(4, 32'h0); rd(4);
                      msg_clr(8'h42, 4, 32'h1); rd(4); clr(4, 32'h1); rd(4); read_all();
    cur_tag = "R8";   rd(0); idle(); idle(); rd(5); rd(6); rd(7); idle();
    cur_tag = "R10";  for (int k = 0; k < 4; k++) clr(k, '1);
                      msg(8'h10); msg(8'h11); msg(8'h12); msg(8'h13); read_all();
                      clr(2, 32'h10); read_all();
    cur_tag = "R10";
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: msg(8'($urandom));
        1: rd(int'($urandom_range(0, 7)));
        2: clr(int'($urandom_range(0, 4)), $urandom);
        default: msg_clr(8'($urandom), int'($urandom_range(0, 4)), $urandom);
      endcase
    end
    read_all();
    report();
  end
endmodule